// File: doc/BRIEF.md
# Serial DAC Word Receiver

This block is the digital receive side of a 16-bit serial-input digital-to-analog converter. A host frames each transfer by pulling an active-low select line low. It then presents one data bit per serial clock, most significant bit first. Each rising serial clock edge inside a frame shifts one bit into a word register. The shifted word is copied into a code latch that drives the converter core. The copy happens either when the select line returns high or later, when an active-low load strobe falls.

All four serial pins are sampled by the block's system clock through a synchronizer chain, and all edge decisions are taken in that clock domain. The latch resets to zero. The word register has no reset, so a short first frame leaves unknown bits in it. A frame longer than the word keeps only its final bits. A short frame leaves the older bits shifted up in front of the new ones. A one-cycle pulse marks every latch update. A second output gives a two's-complement view of the code when the converter runs in bipolar mode, where the code is offset binary.

Top module: `sdac_frontend`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dac_code` becomes 0x0000 and `upd_pulse` becomes 0.
- R2: A frame of exactly 16 bits, sent MSB first while `cs_n` is low and with `ld_n` held low, sets `dac_code` to that word after `cs_n` rises.
- R3: A frame of more than 16 bits loads the last 16 bits clocked in; the earlier ones are dropped.
- R4: A frame of n < 16 bits loads {previous word bits [15-n:0], new n bits}, so the stale bits move up by n places.
- R5: Toggling `sclk` and `din` while `cs_n` is high changes neither the word register nor `dac_code`. A later load strobe then reloads the unchanged previous word.
- R6: If `ld_n` is high when `cs_n` rises, `dac_code` does not change. A later falling edge of `ld_n` while `cs_n` is high loads the word.
- R7: `upd_pulse` is high for exactly one cycle per load, and `dac_code` changes only in a cycle where `upd_pulse` is high.
- R8: `signed_code` equals `dac_code` when `bip_mode` is 0. When `bip_mode` is 1, it equals `dac_code` with bit 15 inverted: 0x8000 maps to 0x0000, and 0x0000 maps to 0x8000.
- R9: A falling edge of `ld_n` while `cs_n` is low does not load. The word is loaded when `cs_n` later rises with `ld_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, MSB first |
| ld_n | input | 1 | Active-low load strobe; hold low for load on frame end |
| bip_mode | input | 1 | 1 selects the bipolar (offset binary) interpretation |
| dac_code | output | 16 | Latched code for the converter core |
| signed_code | output | 16 | Two's-complement view of the code in bipolar mode |
| upd_pulse | output | 1 | One-cycle pulse on each latch update |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a two-stage synchronizer and the load strobe enabled. The strobe option is exercised both ways by holding `ld_n` low, which gives immediate loads at frame end, and by keeping it high, which gives deferred loads. The 16-bit word makes the boundary frames easy to reach: 8-, 17- and 20-bit frames. The bench runs the serial clock at eight system cycles per bit, so synchronizer latency never hides an edge.

// File: rtl/sdac_pkg.sv
// Shared types for the serial DAC receiver.
// Assumes single system clock domain after synchronization.
package sdac_pkg;

    // Raw serial pins bundled for synchronization
    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic ld_n;
        logic din;
    } sdac_pins_t;

    localparam int PIN_W = $bits(sdac_pins_t);

    // Reset image of the synchronizer: select idle high, strobe low, clock low.
    // Choosing ld_n low means a released strobe only produces a harmless rise.
    localparam sdac_pins_t PIN_RST = '{sclk: 1'b0, cs_n: 1'b1, ld_n: 1'b0, din: 1'b0};

    // Events derived from the synchronized pins
    typedef struct packed {
        logic sclk_rise;
        logic cs_rise;
        logic ld_fall;
        logic cs_high;
        logic ld_low;
        logic din;
    } sdac_evt_t;

endpackage

// File: rtl/sdac_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes inputs change far slower than clk; all bits share one chain
// so their relative order is kept.
module sdac_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sdac_edges.sv
// Turns synchronized pins into edge and level events.
// Assumes its input is already in the clk domain.
module sdac_edges
    import sdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sdac_pins_t pins,
    output sdac_evt_t  evt
);

    sdac_pins_t prev_q;

    // Remember last synchronized pin values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= PIN_RST;
        else        prev_q <= pins;
    end

    // Decode edges and levels
    always_comb begin
        evt.sclk_rise = pins.sclk & ~prev_q.sclk;
        evt.cs_rise   = pins.cs_n & ~prev_q.cs_n;
        evt.ld_fall   = ~pins.ld_n & prev_q.ld_n;
        evt.cs_high   = pins.cs_n;
        evt.ld_low    = ~pins.ld_n;
        evt.din       = pins.din;
    end

endmodule

// File: rtl/sdac_shifter.sv
// Input word register: shifts in one bit per serial clock rise inside a frame.
// Deliberately has no reset; its contents are undefined until filled.
module sdac_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] word_q;

    // MSB-first shift; older bits move toward the top and fall off
    always_ff @(posedge clk) begin
        if (shift_en) word_q <= {word_q[WORD_W-2:0], din};
    end

    assign word = word_q;

endmodule

// File: rtl/sdac_loader.sv
// Code latch and update pulse. LOAD_STROBE_EN selects whether the
// active-low strobe gates frame-end loads and allows deferred loads.
// Assumes frame-end and strobe edges never coincide with a shift.
module sdac_loader
    import sdac_pkg::*;
#(
    parameter int WORD_W        = 16,
    parameter bit LOAD_STROBE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdac_evt_t         evt,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] code,
    output logic              upd
);

    logic              load;
    logic [WORD_W-1:0] code_q;
    logic              upd_q;

    generate
        if (LOAD_STROBE_EN) begin : g_strobe
            // Frame end loads only with strobe low; strobe fall loads outside a frame
            assign load = (evt.cs_rise & evt.ld_low) | (evt.ld_fall & evt.cs_high);
        end else begin : g_direct
            // Strobe ignored: every frame end loads
            logic unused_ld;
            assign unused_ld = evt.ld_fall ^ evt.ld_low;
            assign load = evt.cs_rise;
        end
    endgenerate

    // Latch update with one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= load;
            if (load) code_q <= word;
        end
    end

    assign code = code_q;
    assign upd  = upd_q;

endmodule

// File: rtl/sdac_frontend.sv
// Top of the serial DAC receiver: synchronizes pins, detects edges,
// shifts frames into the word register and loads the code latch.
// Assumes sclk, cs_n, ld_n and din each hold for several clk cycles.
module sdac_frontend
    import sdac_pkg::*;
#(
    parameter int WORD_W         = 16,
    parameter int SYNC_STAGES    = 2,
    parameter bit LOAD_STROBE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    input  logic              ld_n,
    input  logic              bip_mode,
    output logic [WORD_W-1:0] dac_code,
    output logic [WORD_W-1:0] signed_code,
    output logic              upd_pulse
);

    localparam int MSB = WORD_W - 1;

    sdac_pins_t        raw_pins;
    sdac_pins_t        sync_pins;
    sdac_evt_t         evt;
    logic              cs_s;
    logic              shift_en;
    logic [WORD_W-1:0] shift_q;

    // Bundle raw pins
    always_comb begin
        raw_pins.sclk = sclk;
        raw_pins.cs_n = cs_n;
        raw_pins.ld_n = ld_n;
        raw_pins.din  = din;
    end

    sdac_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_pins),
        .q    (sync_pins)
    );

    sdac_edges u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .pins (sync_pins),
        .evt  (evt)
    );

    assign cs_s     = evt.cs_high;
    assign shift_en = evt.sclk_rise & ~evt.cs_high;

    sdac_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk     (clk),
        .shift_en(shift_en),
        .din     (evt.din),
        .word    (shift_q)
    );

    sdac_loader #(
        .WORD_W        (WORD_W),
        .LOAD_STROBE_EN(LOAD_STROBE_EN)
    ) u_load (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt),
        .word (shift_q),
        .code (dac_code),
        .upd  (upd_pulse)
    );

    // Offset binary to two's complement in bipolar mode
    always_comb begin
        signed_code = dac_code;
        if (bip_mode) signed_code[MSB] = ~dac_code[MSB];
    end

endmodule

// File: rtl/sdac_frontend_chk.sv
// Property checker for sdac_frontend, attached by bind.
module sdac_frontend_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_pulse,
    input logic [WORD_W-1:0] dac_code,
    input logic              cs_s,
    input logic [WORD_W-1:0] shift_q
);

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (dac_code == '0 && !upd_pulse)); // R1
    AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (!rst_n) upd_pulse |-> dac_code == $past(shift_q)); // R2
    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> $stable(shift_q)); // R5
    AST_CODE_CHANGES_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (dac_code != $past(dac_code)) |-> upd_pulse); // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) upd_pulse |=> !upd_pulse); // R7
    AST_NO_LOAD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !cs_s |=> !upd_pulse); // R9

endmodule

bind sdac_frontend sdac_frontend_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_pulse(upd_pulse),
    .dac_code (dac_code),
    .cs_s     (cs_s),
    .shift_q  (shift_q)
);

// File: tb/tb_sdac_frontend.sv
module tb_sdac_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        ld_n = 1'b0;
    logic        bip_mode = 1'b0;
    logic [15:0] dac_code;
    logic [15:0] signed_code;
    logic        upd_pulse;

    int          n_checks = 0;
    int          n_fail = 0;
    int          n_pulses = 0;
    bit          done = 1'b0;
    logic [15:0] model = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdac_frontend dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .ld_n(ld_n), .bip_mode(bip_mode), .dac_code(dac_code),
        .signed_code(signed_code), .upd_pulse(upd_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift n bits of 'bits', MSB first, leaving cs_n low
    task automatic shift_bits(input logic [31:0] bits, input int n);
        cs_n = 1'b0;
        wait_clk(HALF_BIT);
        for (int i = n - 1; i >= 0; i--) begin
            din = bits[i];
            wait_clk(HALF_BIT);
            sclk = 1'b1;
            model = {model[14:0], bits[i]};
            wait_clk(HALF_BIT);
            sclk = 1'b0;
        end
        wait_clk(HALF_BIT);
    endtask

    task automatic expect_load(input string tag);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    // Full frame with immediate load
    task automatic frame(input logic [31:0] bits, input int n, input string tag);
        shift_bits(bits, n);
        expect_load(tag);
        end_frame();
    endtask

    // Monitor: compare each update against the scoreboard
    always @(negedge clk) begin
        if (rst_n && upd_pulse) begin
            n_pulses++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected update", dac_code, model);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dac_code == e, t, dac_code, e);
            end
        end
    end

    initial begin
        int p0;
        wait_clk(4);
        // R1: reset state
        check(dac_code == 16'h0000, "R1 code after reset", dac_code, 16'h0000);
        check(upd_pulse == 1'b0, "R1 pulse after reset", {15'b0, upd_pulse}, 16'h0000);
        rst_n = 1'b1;
        wait_clk(6);
        check(dac_code == 16'h0000, "R1 code before first load", dac_code, 16'h0000);

        // R2: exact frames
        frame(32'hA5C3, 16, "R2 word A5C3");
        frame(32'h1234, 16, "R2 word 1234");
        frame(32'hFFFF, 16, "R2 word FFFF");
        frame(32'h0000, 16, "R2 word 0000");
        frame(32'hA5C3, 16, "R2 word A5C3 again");

        // R4: short frame keeps stale bits
        frame(32'h3C, 8, "R4 8-bit frame");
        check(dac_code == 16'hC33C, "R4 stale bits shifted up", dac_code, 16'hC33C);

        // R3: overlong frames
        frame(32'h1BEEF, 17, "R3 17-bit frame");
        check(dac_code == 16'hBEEF, "R3 last 16 of 17", dac_code, 16'hBEEF);
        frame(32'hFCAFE, 20, "R3 20-bit frame");
        check(dac_code == 16'hCAFE, "R3 last 16 of 20", dac_code, 16'hCAFE);

        // R5: activity with cs_n high has no effect
        ld_n = 1'b1;
        wait_clk(8);
        p0 = n_pulses;
        for (int i = 0; i < 8; i++) begin
            din = i[0];
            wait_clk(HALF_BIT);
            sclk = 1'b1;
            wait_clk(HALF_BIT);
            sclk = 1'b0;
        end
        wait_clk(8);
        check(n_pulses == p0, "R5 no update while deselected", n_pulses[15:0], p0[15:0]);
        check(dac_code == 16'hCAFE, "R5 code unchanged", dac_code, 16'hCAFE);
        expect_load("R5 strobe reloads unchanged word");
        ld_n = 1'b0;
        wait_clk(12);
        check(n_pulses == p0 + 1, "R5 strobe load happened", n_pulses[15:0], 16'(p0 + 1));

        // R6: deferred load
        ld_n = 1'b1;
        wait_clk(8);
        shift_bits(32'h7E81, 16);
        p0 = n_pulses;
        end_frame();
        check(dac_code == 16'hCAFE, "R6 held while strobe high", dac_code, 16'hCAFE);
        check(n_pulses == p0, "R6 no pulse at frame end", n_pulses[15:0], p0[15:0]);
        expect_load("R6 deferred load");
        ld_n = 1'b0;
        wait_clk(12);
        check(dac_code == 16'h7E81, "R6 code after strobe", dac_code, 16'h7E81);

        // R9: strobe falling inside a frame does not load
        ld_n = 1'b1;
        wait_clk(8);
        shift_bits(32'h8000, 16);
        p0 = n_pulses;
        ld_n = 1'b0;
        wait_clk(12);
        check(n_pulses == p0, "R9 no load inside frame", n_pulses[15:0], p0[15:0]);
        check(dac_code == 16'h7E81, "R9 code held inside frame", dac_code, 16'h7E81);
        expect_load("R9 load at frame end");
        end_frame();
        check(dac_code == 16'h8000, "R9 code after frame end", dac_code, 16'h8000);

        // R8: bipolar view
        check(signed_code == 16'h8000, "R8 unipolar passthrough", signed_code, 16'h8000);
        bip_mode = 1'b1;
        wait_clk(1);
        check(signed_code == 16'h0000, "R8 bipolar midscale", signed_code, 16'h0000);
        frame(32'h0000, 16, "R8 load zero");
        check(signed_code == 16'h8000, "R8 bipolar negative full", signed_code, 16'h8000);
        frame(32'hFFFF, 16, "R8 load full");
        check(signed_code == 16'h7FFF, "R8 bipolar positive full", signed_code, 16'h7FFF);

        // R7: every expected update was seen
        check(exp_q.size() == 0, "R7 all updates seen", 16'(exp_q.size()), 16'h0000);
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule